// File: doc/BRIEF.md
# Frame reject and tag serializer

This block sits beside the receive path of a single Ethernet port and acts on the destination-address lookup result for the frame now arriving. It runs on the receive nibble clock. It tracks the frame itself: the preamble, the start-of-frame delimiter, and a nibble counter that starts after the delimiter. It then judges each lookup result that arrives inside the frame.

A unicast hit whose stored destination port equals the port the frame came in on is a frame that would go back to its own segment. For such a frame the block raises a reject line toward the MAC. It also forces the receive-error line that the MAC sees, so the MAC drops the frame. A unicast hit on any other port sends that port number out serially on a tag line, qualified by a tag-valid line. Broadcast, multicast and unicast misses pass with no action.

A result must arrive within 128 nibble clocks (512 bit times) after the delimiter. A result that arrives later takes no action and sets a sticky late indication. Both the reject and the forced error drop when the frame ends.

Top module: `frame_reject_tagger`

## Requirements
- R1: After reset, `tag_dv` and `late_flag` are 0, the internal reject is inactive (so `rej` equals `cfg_rej_low`), and `frx_er` follows `rx_er`.
- R2: A result sampled as accepted, with `res_kind` = 2'b10 (unicast), `res_hit` = 1 and `res_port` equal to `src_port`, makes the reject active from the cycle after the strobe. It stays active until the frame ends.
- R3: `rej` shows the internal reject as active high when `cfg_rej_low` = 0 and as active low when `cfg_rej_low` = 1.
- R4: `frx_er` is at all times the OR of the `rx_er` input and the internal reject.
- R5: An accepted unicast hit whose `res_port` differs from `src_port` drives `tag_dv` high for exactly 6 cycles, starting the cycle after the strobe. During those cycles `tag_sd` carries `res_port` with the most significant bit first, one bit per cycle.
- R6: A strobe sampled while the post-delimiter count is below 128 is acted on. The count is 0 in the cycle right after the delimiter nibble and rises by one each cycle. A strobe sampled at count 128 or later causes neither reject nor tag, and it sets `late_flag`, which stays 1 until reset.
- R7: When `rx_dv` is sampled low, the reject is cleared in the next cycle, and `frx_er` then equals `rx_er` again.
- R8: Results with `res_kind` 2'b00 (broadcast) or 2'b01 (multicast), 2'b11 (reserved), or a unicast with `res_hit` = 0 never cause a reject or a tag.
- R9: The delimiter is a nibble 4'hD sampled with `rx_dv` high directly after a nibble 4'h5 of the same frame. A strobe before the delimiter has no effect, and so does a strobe with `rx_dv` low, or any strobe after the first one in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rej_low | input | 1 | 1 selects active-low `rej` |
| rx_dv | input | 1 | Receive data valid from the PHY |
| rx_er | input | 1 | Receive error from the PHY |
| rxd | input | 4 | Receive data nibble |
| res_vld | input | 1 | One-cycle strobe for a lookup result |
| res_kind | input | 2 | Frame class: 00 broadcast, 01 multicast, 10 unicast, 11 reserved |
| res_hit | input | 1 | Destination address found in the table |
| res_port | input | 6 | Destination port ID from the lookup |
| src_port | input | 6 | ID of the receiving port |
| rej | output | 1 | Reject toward the MAC, polarity set by `cfg_rej_low` |
| frx_er | output | 1 | Receive error merged with the reject |
| tag_sd | output | 1 | Serial destination port, MSB first |
| tag_dv | output | 1 | High while tag bits remain to be sent |
| late_flag | output | 1 | Sticky: a result arrived after the window |

## Verification
The assertions take four things for granted about the inputs:
- Frames are separated by at least one cycle with `rx_dv` low.
- `res_vld` is a single-cycle pulse.
- `cfg_rej_low` and `src_port` change only between frames.
- A new tag load may cut short a tag still being sent.

The stimulus builds every frame as a run of 4'h5 nibbles, one 4'hD nibble and a random body, followed by an idle gap. It changes the configuration and source port only in that gap. Result strobes are placed at chosen nibble positions, including positions inside the preamble, on the delimiter nibble, at counts 127 and 128, after a first strobe, and in the idle gap.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic [1:0] {
        KIND_BCAST = 2'b00,
        KIND_MCAST = 2'b01,
        KIND_UCAST = 2'b10,
        KIND_RSVD  = 2'b11
    } fr_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_BODY = 2'd2
    } fr_phase_e;

    localparam logic [3:0] NIB_PREAMBLE = 4'h5;
    localparam logic [3:0] NIB_SFD      = 4'hD;

    typedef struct packed {
        logic accept;
        logic late;
    } fr_gate_t;

    function automatic logic fr_is_ucast_hit(input logic [1:0] kind, input logic hit);
        return (fr_kind_e'(kind) == KIND_UCAST) && hit;
    endfunction

endpackage

// File: rtl/fr_delim_track.sv
module fr_delim_track #(
    parameter int WIN_NIBBLES = 128,
    localparam int CNT_W = $clog2(WIN_NIBBLES + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rx_dv,
    input  logic [3:0]     rxd,
    input  logic           res_vld,
    output fr_pkg::fr_gate_t gate,
    output logic           late_flag
);
    import fr_pkg::*;

    fr_phase_e        phase;
    logic [3:0]       prev_nib;
    logic [CNT_W-1:0] cnt;
    logic             done;
    logic             sfd_now;

    localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(WIN_NIBBLES);

    assign sfd_now = (prev_nib == NIB_PREAMBLE) && (rxd == NIB_SFD);

    always_comb begin
        gate = '0;
        if (phase == PH_BODY && rx_dv && res_vld && !done) begin
            gate.accept = (cnt < WIN_LIM);
            gate.late   = (cnt >= WIN_LIM);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            prev_nib  <= '0;
            cnt       <= '0;
            done      <= 1'b0;
            late_flag <= 1'b0;
        end else begin
            if (gate.late)
                late_flag <= 1'b1;
            if (!rx_dv) begin
                phase    <= PH_IDLE;
                prev_nib <= '0;
                cnt      <= '0;
                done     <= 1'b0;
            end else begin
                prev_nib <= rxd;
                if (phase != PH_BODY) begin
                    phase <= sfd_now ? PH_BODY : PH_PRE;
                    cnt   <= '0;
                end else begin
                    if (cnt != WIN_LIM)
                        cnt <= cnt + 1'b1;
                    if (res_vld)
                        done <= 1'b1;
                end
            end
        end
    end

    a_r6_late_sticky: assert property (@(posedge clk) disable iff (rst)
        late_flag |=> late_flag);

    a_r6_late_sets: assert property (@(posedge clk) disable iff (rst)
        gate.late |=> late_flag);

    a_r9_one_result: assert property (@(posedge clk) disable iff (rst)
        (gate.accept || gate.late) |=> !(gate.accept || gate.late));

endmodule

// File: rtl/fr_reject_ctl.sv
module fr_reject_ctl #(
    parameter int PORT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_dv,
    input  logic              accept,
    input  logic [1:0]        kind,
    input  logic              hit,
    input  logic [PORT_W-1:0] dst_port,
    input  logic [PORT_W-1:0] src_port,
    output logic              rej_int,
    output logic              tag_load
);
    import fr_pkg::*;

    logic uhit;
    logic same_port;

    assign uhit      = accept && fr_is_ucast_hit(kind, hit);
    assign same_port = uhit && (dst_port == src_port);
    assign tag_load  = uhit && (dst_port != src_port);

    always_ff @(posedge clk) begin
        if (rst)
            rej_int <= 1'b0;
        else if (!rx_dv)
            rej_int <= 1'b0;
        else if (same_port)
            rej_int <= 1'b1;
    end

    a_r2_reject_follows: assert property (@(posedge clk) disable iff (rst)
        (accept && rx_dv && kind == 2'b10 && hit && dst_port == src_port) |=> rej_int);

    a_r7_clear_at_end: assert property (@(posedge clk) disable iff (rst)
        !rx_dv |=> !rej_int);

    a_r8_no_reject_other: assert property (@(posedge clk) disable iff (rst)
        (accept && !(kind == 2'b10 && hit) && !rej_int) |=> !rej_int);

endmodule

// File: rtl/fr_tag_shift.sv
module fr_tag_shift #(
    parameter int PORT_W = 6,
    localparam int LEFT_W = $clog2(PORT_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PORT_W-1:0] data,
    output logic              tag_sd,
    output logic              tag_dv
);
    logic [PORT_W-1:0] sreg;
    logic [LEFT_W-1:0] left;

    localparam logic [LEFT_W-1:0] FULL = LEFT_W'(PORT_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            left <= '0;
        end else if (load) begin
            sreg <= data;
            left <= FULL;
        end else if (left != '0) begin
            sreg <= {sreg[PORT_W-2:0], 1'b0};
            left <= left - 1'b1;
        end
    end

    assign tag_sd = sreg[PORT_W-1];
    assign tag_dv = (left != '0);

    a_r5_full_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (tag_dv && left == FULL));

    a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
        (tag_dv && !load) |=> (left == $past(left) - 1'b1));

endmodule

// File: rtl/frame_reject_tagger.sv
module frame_reject_tagger #(
    parameter int PORT_W      = 6,
    parameter int WIN_NIBBLES = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_rej_low,
    input  logic              rx_dv,
    input  logic              rx_er,
    input  logic [3:0]        rxd,
    input  logic              res_vld,
    input  logic [1:0]        res_kind,
    input  logic              res_hit,
    input  logic [PORT_W-1:0] res_port,
    input  logic [PORT_W-1:0] src_port,
    output logic              rej,
    output logic              frx_er,
    output logic              tag_sd,
    output logic              tag_dv,
    output logic              late_flag
);
    fr_pkg::fr_gate_t gate;
    logic             rej_int;
    logic             tag_load;

    fr_delim_track #(.WIN_NIBBLES(WIN_NIBBLES)) u_delim (
        .clk       (clk),
        .rst       (rst),
        .rx_dv     (rx_dv),
        .rxd       (rxd),
        .res_vld   (res_vld),
        .gate      (gate),
        .late_flag (late_flag)
    );

    fr_reject_ctl #(.PORT_W(PORT_W)) u_rej (
        .clk      (clk),
        .rst      (rst),
        .rx_dv    (rx_dv),
        .accept   (gate.accept),
        .kind     (res_kind),
        .hit      (res_hit),
        .dst_port (res_port),
        .src_port (src_port),
        .rej_int  (rej_int),
        .tag_load (tag_load)
    );

    fr_tag_shift #(.PORT_W(PORT_W)) u_tag (
        .clk    (clk),
        .rst    (rst),
        .load   (tag_load),
        .data   (res_port),
        .tag_sd (tag_sd),
        .tag_dv (tag_dv)
    );

    assign rej    = rej_int ^ cfg_rej_low;
    assign frx_er = rx_er | rej_int;

    a_r4_error_forced: assert property (@(posedge clk) disable iff (rst)
        rej_int |-> frx_er);

    a_r4_error_passes: assert property (@(posedge clk) disable iff (rst)
        rx_er |-> frx_er);

    a_r8_no_tag_other: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !(res_kind == 2'b10 && res_hit) && !tag_dv) |=> !tag_dv);

endmodule

// File: tb/test_frame_reject_tagger.sv
module test_frame_reject_tagger;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_rej_low = 1'b0;
    logic       rx_dv = 1'b0;
    logic       rx_er = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic       res_vld = 1'b0;
    logic [1:0] res_kind = 2'b00;
    logic       res_hit = 1'b0;
    logic [5:0] res_port = 6'd0;
    logic [5:0] src_port = 6'd0;
    logic       rej, frx_er, tag_sd, tag_dv, late_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    string cur_req = "R1";

    // reference model state
    int         m_ph = 0;
    logic [3:0] m_prev = 4'h0;
    int         m_cnt = 0;
    bit         m_done = 0;
    bit         m_rej = 0;
    logic [5:0] m_sr = 6'd0;
    int         m_left = 0;
    bit         m_late = 0;

    always #2.5 clk = ~clk;

    frame_reject_tagger i_frame_reject_tagger (
        .clk(clk), .rst(rst), .cfg_rej_low(cfg_rej_low), .rx_dv(rx_dv),
        .rx_er(rx_er), .rxd(rxd), .res_vld(res_vld), .res_kind(res_kind),
        .res_hit(res_hit), .res_port(res_port), .src_port(src_port),
        .rej(rej), .frx_er(frx_er), .tag_sd(tag_sd), .tag_dv(tag_dv),
        .late_flag(late_flag)
    );

    task automatic check(string req, string name, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, name, got, exp, $time);
        end
    endtask

    function automatic bit is_ucast_hit(logic [1:0] k, logic h);
        return (k == 2'b10) && h;
    endfunction

    task automatic model_update();
        bit acc = 0;
        if (!rx_dv) begin
            m_ph = 0; m_prev = 4'h0; m_cnt = 0; m_done = 0; m_rej = 0;
        end else begin
            if (m_ph == 2 && res_vld && !m_done) begin
                if (m_cnt < 128) acc = 1; else m_late = 1;
            end
            if (m_ph != 2) begin
                m_ph = (m_prev == 4'h5 && rxd == 4'hD) ? 2 : 1;
                m_cnt = 0;
            end else begin
                if (m_cnt < 128) m_cnt++;
                if (res_vld) m_done = 1;
            end
            m_prev = rxd;
            if (acc && is_ucast_hit(res_kind, res_hit) && res_port == src_port)
                m_rej = 1;
        end
        if (acc && is_ucast_hit(res_kind, res_hit) && res_port != src_port) begin
            m_sr = res_port; m_left = 6;
        end else if (m_left > 0) begin
            m_sr = {m_sr[4:0], 1'b0}; m_left--;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(cur_req, "rej (R3 polarity)", rej, m_rej ^ cfg_rej_low);
        check(cur_req, "frx_er (R4)", frx_er, rx_er | m_rej);
        check("R5", "tag_dv", tag_dv, m_left > 0);
        if (m_left > 0) check("R5", "tag_sd", tag_sd, m_sr[5]);
        check("R6", "late_flag", late_flag, m_late);
    endtask

    task automatic frame(int pre, int body, int s1, int s2, logic [1:0] k,
                         logic h, logic [5:0] p, int er_pct, bit gap_strobe, string lbl);
        int total = pre + 1 + body;
        res_kind = k; res_hit = h; res_port = p;
        for (int i = 0; i < total; i++) begin
            rx_dv = 1'b1;
            rxd = (i < pre) ? 4'h5 : (i == pre) ? 4'hD : 4'($urandom);
            rx_er = (int'($urandom % 100) < er_pct);
            res_vld = (i == s1) || (i == s2);
            cur_req = lbl;
            step();
        end
        for (int g = 0; g < 3; g++) begin
            rx_dv = 1'b0; rx_er = 1'b0; rxd = 4'h0;
            res_vld = gap_strobe && (g == 0);
            cur_req = "R7";
            step();
        end
        res_vld = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "rej", rej, 1'b0);
        check("R1", "frx_er", frx_er, 1'b0);
        check("R1", "tag_dv", tag_dv, 1'b0);
        check("R1", "late_flag", late_flag, 1'b0);
        rst = 1'b0;

        src_port = 6'd9;
        // R2 same-port unicast hit rejects
        frame(7, 40, 20, -1, 2'b10, 1'b1, 6'd9, 0, 0, "R2");
        // R3 active-low reject, with R4 error merge
        cfg_rej_low = 1'b1;
        frame(5, 40, 12, -1, 2'b10, 1'b1, 6'd9, 20, 0, "R3");
        cfg_rej_low = 1'b0;
        frame(4, 30, 10, -1, 2'b10, 1'b1, 6'd9, 30, 0, "R4");
        // R5 tag for a different port
        frame(7, 30, 9, -1, 2'b10, 1'b1, 6'b101101, 0, 0, "R5");
        frame(7, 30, 9, -1, 2'b10, 1'b1, 6'b010011, 0, 0, "R5");
        // R8 broadcast, multicast, reserved, miss
        frame(7, 20, 9, -1, 2'b00, 1'b1, 6'd9, 0, 0, "R8");
        frame(7, 20, 9, -1, 2'b01, 1'b1, 6'd9, 0, 0, "R8");
        frame(7, 20, 9, -1, 2'b11, 1'b1, 6'd9, 0, 0, "R8");
        frame(7, 20, 9, -1, 2'b10, 1'b0, 6'd9, 0, 0, "R8");
        // R9 strobe in preamble, on delimiter, in gap, second strobe
        frame(7, 20, 3, -1, 2'b10, 1'b1, 6'd9, 0, 1, "R9");
        frame(7, 20, 7, -1, 2'b10, 1'b1, 6'd9, 0, 0, "R9");
        frame(7, 20, 9, 12, 2'b10, 1'b1, 6'd3, 0, 0, "R9");
        frame(0, 20, 4, -1, 2'b10, 1'b1, 6'd9, 0, 0, "R9");
        // R6 window edge: count 127 accepted, count 128 late
        frame(7, 140, 7 + 1 + 127, -1, 2'b10, 1'b1, 6'd9, 0, 0, "R6");
        check("R6", "late_flag before late strobe", late_flag, 1'b0);
        frame(7, 140, 7 + 1 + 128, -1, 2'b10, 1'b1, 6'd9, 0, 0, "R6");
        check("R6", "late_flag after late strobe", late_flag, 1'b1);

        // random frames
        for (int f = 0; f < 40; f++) begin
            int pre  = int'($urandom % 15);
            int body = 10 + int'($urandom % 160);
            int tot  = pre + 1 + body;
            int s1   = int'($urandom % (tot + 4));
            int s2   = ($urandom % 4 == 0) ? int'($urandom % (tot + 4)) : -1;
            logic [5:0] sp = 6'($urandom);
            logic [5:0] pp = ($urandom % 3 == 0) ? sp : 6'($urandom);
            src_port = sp;
            cfg_rej_low = 1'($urandom);
            frame(pre, body, s1, s2, 2'($urandom), 1'($urandom), pp, 5,
                  1'($urandom), "R2");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule